// File: doc/BRIEF.md
# Multi-speed I2C SCL timing generator

This block produces the serial clock waveform for an I2C master that runs in one of three speed classes: standard, fast and high-speed. Each class owns a pair of programmable counts, one for the low phase and one for the high phase of SCL. A two-bit speed code picks the pair. Every phase is timed by counting system clock cycles up to the selected count.

The count pairs are loaded through a simple byte-addressed register write port. The pairs sit at a fixed stride of 8 bytes, one pair per speed class. The port is a plain single-cycle strobe with no back-pressure: a write is taken on any clock edge where `cfg_wr` is high.

While the block is disabled SCL is held high. Once it is enabled, SCL starts with a low phase and then alternates. The phase strobes mark each edge of SCL for the start/stop and data-shifting logic that sits around this block. A new count or speed code is picked up only when a phase ends, so the phase in progress is never cut short or stretched.

Top module: `scl_speed_timer`

## Requirements
- R1: After reset `scl_o` is 1 and both strobes are 0. The count registers hold these defaults (high/low): standard 0x75/0x7C, fast 0x15/0x21, high-speed 0x07/0x0E.
- R2: While `enable` is 0, `scl_o` is 1 from the next cycle on and `scl_fall` stays 0.
- R3: When `enable` goes from 0 to 1, the next clock edge drives `scl_o` low and pulses `scl_fall`. The low phase therefore comes first.
- R4: Once running, each low phase lasts exactly the effective low count of the latched speed class in clock cycles. Each high phase lasts exactly the effective high count.
- R5: The speed code `speed_sel` maps as follows: 1 selects standard, 2 selects fast, 3 selects high-speed, and 0 is treated as standard.
- R6: Class index m is 0 for standard, 1 for fast and 2 for high-speed. Its high count is written at byte address 0x14+8m and its low count at 0x18+8m. Writes to any other address change no timing.
- R7: A programmed count of 0 acts as 1, so no phase is ever zero cycles long and the two strobes are never high together.
- R8: A write to a count register, or a change of `speed_sel`, does not alter the phase in progress. It applies from the next phase boundary on.
- R9: `scl_fall` is high for exactly the cycle in which `scl_o` has just gone from 1 to 0. `scl_rise` is high for exactly the cycle in which it has just gone from 0 to 1, including the return to high on disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL generator; 0 holds SCL high |
| speed_sel | input | 2 | Speed code (0/1 standard, 2 fast, 3 high-speed) |
| cfg_wr | input | 1 | Count register write strobe |
| cfg_addr | input | 8 | Byte address of the count register |
| cfg_wdata | input | 16 | Count value to write |
| scl_o | output | 1 | SCL drive level |
| scl_fall | output | 1 | One-cycle strobe after SCL falls |
| scl_rise | output | 1 | One-cycle strobe after SCL rises |

## Verification
The reset defaults are measured for all three classes before anything is written, which tests the reset values and the speed decode together. A sweep then programs every class at once with different pairs, zeros included, and runs each of the four speed codes. A swapped address decode, a wrong code mapping or a missing zero-to-one clamp each give a phase length different from the arithmetic expectation. Directed sequences cover the rest. Mid-phase writes and a mid-phase speed change show that lengths switch only at a boundary. Writes to foreign addresses must leave the timing untouched. A disable during a low phase must return SCL high with a rise strobe.

// File: rtl/scl_tmg_pkg.sv
package scl_tmg_pkg;

  localparam int N_MODES = 3;

  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_FAST = 2'd1,
    MODE_HS   = 2'd2
  } mode_e;

  // speed code to class index; code 0 falls back to standard
  function automatic mode_e mode_of_code(input logic [1:0] code);
    case (code)
      2'd2:    return MODE_FAST;
      2'd3:    return MODE_HS;
      default: return MODE_STD;
    endcase
  endfunction

  // reset value of the high count for class m
  function automatic int unsigned dflt_high(input int unsigned m);
    case (m)
      0:       return 32'h75;
      1:       return 32'h15;
      default: return 32'h07;
    endcase
  endfunction

  // reset value of the low count for class m
  function automatic int unsigned dflt_low(input int unsigned m);
    case (m)
      0:       return 32'h7C;
      1:       return 32'h21;
      default: return 32'h0E;
    endcase
  endfunction

endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs
  import scl_tmg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int HI_BASE = 'h14,
  parameter int STRIDE  = 8,
  parameter int NMODE   = N_MODES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [CNT_W-1:0]             wdata,
  output logic [NMODE-1:0][CNT_W-1:0]  hi_cnt,
  output logic [NMODE-1:0][CNT_W-1:0]  lo_cnt
);

  // the low count of a class sits one word after its high count
  localparam int LO_BASE = HI_BASE + 4;

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(HI_BASE + m * STRIDE);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(LO_BASE + m * STRIDE);
    localparam logic [CNT_W-1:0]  HI_RST  = CNT_W'(dflt_high(m));
    localparam logic [CNT_W-1:0]  LO_RST  = CNT_W'(dflt_low(m));

    logic hit_hi, hit_lo;
    assign hit_hi = wr && (addr == HI_ADDR);
    assign hit_lo = wr && (addr == LO_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_cnt[m] <= HI_RST;
        lo_cnt[m] <= LO_RST;
      end else begin
        if (hit_hi) hi_cnt[m] <= wdata;
        if (hit_lo) lo_cnt[m] <= wdata;
      end
    end
  end

endmodule

// File: rtl/scl_lim_sel.sv
module scl_lim_sel
  import scl_tmg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NMODE = N_MODES
) (
  input  logic [1:0]                   code,
  input  logic [NMODE-1:0][CNT_W-1:0]  hi_cnt,
  input  logic [NMODE-1:0][CNT_W-1:0]  lo_cnt,
  output logic [CNT_W-1:0]             hi_lim,
  output logic [CNT_W-1:0]             lo_lim
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  mode_e            mode;
  logic [CNT_W-1:0] hi_raw, lo_raw;

  always_comb begin
    mode   = mode_of_code(code);
    hi_raw = hi_cnt[int'(mode)];
    lo_raw = lo_cnt[int'(mode)];
    // a zero count still yields a one-cycle phase
    hi_lim = (hi_raw == '0) ? ONE : hi_raw;
    lo_lim = (lo_raw == '0) ? ONE : lo_raw;
  end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] hi_lim,
  input  logic [CNT_W-1:0] lo_lim,
  output logic             scl,
  output logic             fall,
  output logic             rise
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             scl_q, rise_q, fall_q, run_q;
  logic [CNT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      run_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!en) begin
        run_q <= 1'b0;
        cnt_q <= '0;
        if (!scl_q) begin
          scl_q  <= 1'b1;
          rise_q <= 1'b1;
        end
      end else if (!run_q) begin
        // first phase after enable is low
        run_q  <= 1'b1;
        scl_q  <= 1'b0;
        fall_q <= scl_q;
        cnt_q  <= ONE;
        lim_q  <= lo_lim;
      end else if (cnt_q >= lim_q) begin
        // phase boundary: toggle and latch the next limit
        scl_q  <= ~scl_q;
        rise_q <= ~scl_q;
        fall_q <= scl_q;
        cnt_q  <= ONE;
        lim_q  <= scl_q ? lo_lim : hi_lim;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign scl  = scl_q;
  assign fall = fall_q;
  assign rise = rise_q;

endmodule

// File: rtl/scl_speed_timer.sv
module scl_speed_timer
  import scl_tmg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int HI_BASE = 'h14,
  parameter int STRIDE  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        speed_sel,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              scl_o,
  output logic              scl_fall,
  output logic              scl_rise
);

  logic [N_MODES-1:0][CNT_W-1:0] hi_cnt, lo_cnt;
  logic [CNT_W-1:0]              hi_lim, lo_lim;

  scl_cnt_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .HI_BASE(HI_BASE),
    .STRIDE (STRIDE),
    .NMODE  (N_MODES)
  ) i_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .hi_cnt(hi_cnt),
    .lo_cnt(lo_cnt)
  );

  scl_lim_sel #(
    .CNT_W(CNT_W),
    .NMODE(N_MODES)
  ) i_sel (
    .code  (speed_sel),
    .hi_cnt(hi_cnt),
    .lo_cnt(lo_cnt),
    .hi_lim(hi_lim),
    .lo_lim(lo_lim)
  );

  scl_phase_gen #(
    .CNT_W(CNT_W)
  ) i_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .hi_lim(hi_lim),
    .lo_lim(lo_lim),
    .scl   (scl_o),
    .fall  (scl_fall),
    .rise  (scl_rise)
  );

endmodule

// File: rtl/scl_speed_timer_chk.sv
module scl_speed_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_o,
  input logic scl_fall,
  input logic scl_rise
);

  // R9
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall == (!scl_o && $past(scl_o)));

  // R9
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise == (scl_o && !$past(scl_o)));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> scl_o);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> scl_fall);

  // R7
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall && scl_rise));

endmodule

bind scl_speed_timer scl_speed_timer_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .scl_o   (scl_o),
  .scl_fall(scl_fall),
  .scl_rise(scl_rise)
);

// File: tb/test_scl_speed_timer.sv
module test_scl_speed_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  speed_sel = 2'd1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        scl_o, scl_fall, scl_rise;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scl_speed_timer i_scl_speed_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .speed_sel(speed_sel),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .scl_o    (scl_o),
    .scl_fall (scl_fall),
    .scl_rise (scl_rise)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int cls(input int code);
    return (code <= 1) ? 0 : code - 1;
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // count samples at level lvl, starting with pre already counted
  task automatic run_len(input bit lvl, input int pre, input int exp, input string req);
    int n = pre;
    while (scl_o == lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp, req, n, exp);
    chk((lvl ? scl_fall : scl_rise) == 1'b1, "R9", lvl ? scl_fall : scl_rise, 1);
  endtask

  // restart from disabled, then measure one low and one high phase
  task automatic period(input int code, input int lo, input int hi, input string req);
    @(negedge clk);
    enable = 1'b0; speed_sel = 2'(code);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b0 && scl_fall == 1'b1, "R3", scl_fall, 1);
    run_len(1'b0, 0, eff(lo), req);
    run_len(1'b1, 0, eff(hi), req);
    run_len(1'b0, 0, eff(lo), req);
  endtask

  function automatic int lo_of(input int m, input int p);
    return (m * 4 + p * 3 + 1) % 10;
  endfunction
  function automatic int hi_of(input int m, input int p);
    return (m * 5 + p * 2 + 2) % 13;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1 && !scl_fall && !scl_rise, "R1", scl_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b1 && !scl_fall && !scl_rise, "R1", scl_o, 1);

    // reset defaults per class
    period(1, 'h7C, 'h75, "R1 std");
    period(2, 'h21, 'h15, "R1 fast");
    period(3, 'h0E, 'h07, "R1 hs");
    period(0, 'h7C, 'h75, "R5 code0");

    // R2: disabled holds high, no fall strobe
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      chk(scl_o == 1'b1 && !scl_fall, "R2", scl_o, 1);
      @(negedge clk);
    end

    // sweep: all classes programmed, every code, zeros included (R4 R5 R6 R7)
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 3; m++) begin
        wr('h14 + 8 * m, hi_of(m, p));
        wr('h18 + 8 * m, lo_of(m, p));
      end
      for (int c = 0; c < 4; c++)
        period(c, lo_of(cls(c), p), hi_of(cls(c), p), "R4 R5 R6 R7 sweep");
    end

    // R6: foreign addresses ignored
    wr('h14, 3); wr('h18, 2);
    wr('h10, 0); wr('h2C, 9); wr('h16, 0); wr('h1C - 1, 0); wr('h94, 0);
    period(1, 2, 3, "R6 ignored");

    // R8: write mid high phase, then speed change mid low phase
    wr('h14, 6); wr('h18, 4); wr('h1C, 2); wr('h20, 3);
    @(negedge clk); enable = 1'b0; speed_sel = 2'd1;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    run_len(1'b0, 0, 4, "R8 low");
    cfg_wr = 1'b1; cfg_addr = 8'h14; cfg_wdata = 16'd9;
    @(negedge clk);
    cfg_wr = 1'b0;
    run_len(1'b1, 1, 6, "R8 high keeps old");
    speed_sel = 2'd2;
    @(negedge clk);
    run_len(1'b0, 1, 4, "R8 low keeps std");
    run_len(1'b1, 0, 2, "R8 fast high");
    run_len(1'b0, 0, 3, "R8 fast low");
    speed_sel = 2'd1;
    run_len(1'b1, 0, 2, "R8 fast high tail");
    run_len(1'b0, 0, 4, "R8 std low");
    run_len(1'b1, 0, 9, "R8 new high");

    // R9: disable inside a low phase returns high with a rise strobe
    @(negedge clk);
    while (scl_o) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1 && scl_rise == 1'b1, "R9 disable rise", scl_rise, 1);
    @(negedge clk);
    chk(scl_o == 1'b1 && !scl_rise && !scl_fall, "R2 after disable", scl_o, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule